// File: doc/BRIEF.md
# Fractionally Compensated UART Bit Timer

This block produces the timing and the serial waveform for a high-speed UART transmitter that sends frames of one start bit, eight data bits and one stop bit. A prescaler divides the system clock by a programmable quotient to make sample ticks. Each of the ten bit slots of a frame lasts a programmable number of sample ticks. A ten-bit compensation mask can lengthen chosen slots by one tick each. The average bit period can then follow a divisor with a fractional part, adding 0 to 10 ticks per frame, without a fractional accumulator.

A byte is offered on a valid/ready handshake. Once it is accepted, the quotient, the tick count, the sample point and both mask fields are captured, and the whole frame runs on those captured values. A strobe marks the sample point inside every slot. The busy flag covers the frame from its first cycle to its last.

The control is a four-state machine. `TX_IDLE` holds the line high and raises ready. On an accepted byte it goes to `TX_START`, which drives the line low. When the start slot ends it goes to `TX_DATA`, which shifts out the eight data bits LSB first. After the eighth data slot it goes to `TX_STOP`, which drives the line high. When the stop slot ends it returns to `TX_IDLE`.

Top module: `fuart_tx`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_line` is 1, `in_ready` is 1, `busy` is 0 and `samp_strobe` is 0.
- R2: A frame on `tx_line` is slot 0 = 0 (start), slots 1 to 8 = data bits 0 to 7 (LSB first), and slot 9 = 1 (stop). The line is 1 whenever no frame is in progress.
- R3: Slot i lasts (`cfg_samp_cnt`+1+m_i)×`cfg_quot` clock cycles. For slots 0 to 7, m_i is bit i of `cfg_frac_lo`. For slots 8 and 9, m_i is bit 0 or bit 1 of `cfg_frac_hi`.
- R4: `samp_strobe` pulses for one cycle exactly once per slot, in cycle (`cfg_samp_pt`+1)×`cfg_quot` of the slot, counting the slot's first cycle as cycle 1, provided `cfg_samp_pt` ≤ `cfg_samp_cnt`.
- R5: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `busy` is 1 from the next cycle until the frame ends, which is the sum of all ten slot lengths in cycles. `in_ready` is 0 whenever `busy` is 1.
- R6: The configuration inputs are captured at acceptance. Changing them during a frame does not change that frame's slot lengths, strobe positions or data.
- R7: With `cfg_quot`=2, `cfg_samp_cnt`=172, `cfg_samp_pt`=85, `cfg_frac_lo`=0x57 and `cfg_frac_hi`=1, a frame lasts 3472 cycles, which at 40 MHz gives an average bit rate of 115207.
- R8: If `in_valid` stays high with a new byte, the next frame is accepted after exactly one idle cycle, during which the line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_quot | input | QW | Prescaler quotient: clock cycles per sample tick |
| cfg_samp_cnt | input | CW | Sample ticks per bit slot minus one |
| cfg_samp_pt | input | CW | Tick index inside a slot at which the strobe fires |
| cfg_frac_lo | input | LO_W | Stretch mask for slots 0 to 7 |
| cfg_frac_hi | input | HI_W | Stretch mask for slots 8 and 9 |
| in_data | input | DATA_BITS | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte (idle) |
| tx_line | output | 1 | Serial output, idles high |
| samp_strobe | output | 1 | One-cycle pulse at the sample point of each slot |
| busy | output | 1 | Frame in progress |

## Verification
A wrong tick or slot counter shows within one slot as a strobe in the wrong cycle. It also shifts every later slot boundary, so the frame length measured on `busy` comes out wrong when the frame ends. A mask bit applied to the wrong slot leaves the total length right but moves the strobe intervals around the affected slots, so the bench checks every strobe position and not only the total. A wrong shift or data counter shows as a wrong line level at one of the ten strobes of the same frame.

// File: rtl/fuart_pkg.sv
package fuart_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/fuart_prescaler.sv
module fuart_prescaler #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [QW-1:0] quot,
    output logic          tick
);
    logic [QW-1:0] quot_q;
    logic [QW-1:0] pre_q;
    logic [QW:0]   pre_next;

    assign pre_next = {1'b0, pre_q} + (QW+1)'(1);
    // a quotient of zero behaves like one
    assign tick     = run && (pre_next >= {1'b0, quot_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            quot_q <= QW'(1);
        end else if (clear) begin
            pre_q  <= '0;
            quot_q <= quot;
        end else if (run) begin
            if (tick) pre_q <= '0;
            else      pre_q <= pre_next[QW-1:0];
        end
    end

    // R3
    prescale_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (run && quot_q != '0) |-> (pre_q < quot_q));
endmodule

// File: rtl/fuart_slot_timer.sv
module fuart_slot_timer #(
    parameter int CW    = 8,
    parameter int SLOTS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  logic [CW-1:0]    cfg_cnt,
    input  logic [CW-1:0]    cfg_pt,
    input  logic [SLOTS-1:0] cfg_mask,
    output logic             slot_done,
    output logic             strobe
);
    localparam int SW = $clog2(SLOTS + 1);
    localparam int MW = 1 << SW;

    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    pt_q;
    logic [SLOTS-1:0] mask_q;
    logic [CW:0]      bit_cnt;
    logic [SW-1:0]    slot_q;
    logic [MW-1:0]    mask_ext;
    logic             stretch;
    logic [CW:0]      lim;

    assign mask_ext  = MW'(mask_q);
    assign stretch   = mask_ext[slot_q];
    assign lim       = {1'b0, cnt_q} + (CW+1)'(stretch);
    assign slot_done = tick && (bit_cnt == lim);
    assign strobe    = tick && (bit_cnt == {1'b0, pt_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pt_q    <= '0;
            mask_q  <= '0;
            bit_cnt <= '0;
            slot_q  <= '0;
        end else if (start) begin
            cnt_q   <= cfg_cnt;
            pt_q    <= cfg_pt;
            mask_q  <= cfg_mask;
            bit_cnt <= '0;
            slot_q  <= '0;
        end else if (tick) begin
            if (slot_done) begin
                bit_cnt <= '0;
                slot_q  <= slot_q + SW'(1);
            end else begin
                bit_cnt <= bit_cnt + (CW+1)'(1);
            end
        end
    end

    // R3
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= lim);

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(cnt_q) && $stable(pt_q) && $stable(mask_q)));
endmodule

// File: rtl/fuart_frame_fsm.sv
module fuart_frame_fsm
    import fuart_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 slot_done,
    output logic                 in_ready,
    output logic                 busy,
    output logic                 tx_line,
    output logic                 accept
);
    localparam int DW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    tx_state_e            state_q, state_d;
    logic [DATA_BITS-1:0] shreg_q;
    logic [DW-1:0]        dcnt_q;
    logic                 last_data;

    assign last_data = (dcnt_q == DW'(DATA_BITS - 1));
    assign accept    = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (in_valid)               state_d = TX_START;
            TX_START: if (slot_done)              state_d = TX_DATA;
            TX_DATA:  if (slot_done && last_data) state_d = TX_STOP;
            TX_STOP:  if (slot_done)              state_d = TX_IDLE;
            default:                              state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TX_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            dcnt_q  <= '0;
        end else if (accept) begin
            shreg_q <= in_data;
            dcnt_q  <= '0;
        end else if (state_q == TX_DATA && slot_done) begin
            shreg_q <= shreg_q >> 1;
            dcnt_q  <= dcnt_q + DW'(1);
        end
    end

    always_comb begin
        in_ready = 1'b0;
        busy     = 1'b1;
        tx_line  = 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                in_ready = 1'b1;
                busy     = 1'b0;
                tx_line  = 1'b1;
            end
            TX_START: tx_line = 1'b0;
            TX_DATA:  tx_line = shreg_q[0];
            TX_STOP:  tx_line = 1'b1;
            default:  tx_line = 1'b1;
        endcase
    end

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!tx_line && busy));

    // R2
    stop_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tx_line));

    // R5
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);
endmodule

// File: rtl/fuart_tx.sv
module fuart_tx #(
    parameter int QW        = 16,
    parameter int CW        = 8,
    parameter int DATA_BITS = 8,
    parameter int LO_W      = 8,
    parameter int HI_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [QW-1:0]        cfg_quot,
    input  logic [CW-1:0]        cfg_samp_cnt,
    input  logic [CW-1:0]        cfg_samp_pt,
    input  logic [LO_W-1:0]      cfg_frac_lo,
    input  logic [HI_W-1:0]      cfg_frac_hi,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 tx_line,
    output logic                 samp_strobe,
    output logic                 busy
);
    localparam int SLOTS = DATA_BITS + 2;

    logic             tick;
    logic             slot_done;
    logic             accept;
    logic [SLOTS-1:0] mask_all;

    assign mask_all = SLOTS'({cfg_frac_hi, cfg_frac_lo});

    fuart_prescaler #(.QW(QW)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (busy),
        .quot  (cfg_quot),
        .tick  (tick)
    );

    fuart_slot_timer #(.CW(CW), .SLOTS(SLOTS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .tick      (tick),
        .cfg_cnt   (cfg_samp_cnt),
        .cfg_pt    (cfg_samp_pt),
        .cfg_mask  (mask_all),
        .slot_done (slot_done),
        .strobe    (samp_strobe)
    );

    fuart_frame_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .slot_done (slot_done),
        .in_ready  (in_ready),
        .busy      (busy),
        .tx_line   (tx_line),
        .accept    (accept)
    );

    // R4
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        samp_strobe |-> busy);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        samp_strobe |=> !samp_strobe || $past(tick));
endmodule

// File: tb/fuart_tx_tb.sv
module fuart_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 150000;

    typedef struct {
        logic [7:0] data;
        int         q;
        int         n;
        int         pt;
        logic [9:0] mask;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_quot = 16'd1;
    logic [7:0]  cfg_samp_cnt = '0;
    logic [7:0]  cfg_samp_pt = '0;
    logic [7:0]  cfg_frac_lo = '0;
    logic [1:0]  cfg_frac_hi = '0;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, tx_line, samp_strobe, busy;

    int   tests = 0;
    int   fails = 0;
    int   frames_done = 0;
    int   last_len = 0;
    int   last_gap = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fuart_tx u_dut (
        .clk(clk), .rst(rst), .cfg_quot(cfg_quot), .cfg_samp_cnt(cfg_samp_cnt),
        .cfg_samp_pt(cfg_samp_pt), .cfg_frac_lo(cfg_frac_lo), .cfg_frac_hi(cfg_frac_hi),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tx_line(tx_line), .samp_strobe(samp_strobe), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic set_cfg(input int q, input int n, input int pt,
                           input logic [7:0] lo, input logic [1:0] hi);
        cfg_quot     = 16'(q);
        cfg_samp_cnt = 8'(n);
        cfg_samp_pt  = 8'(pt);
        cfg_frac_lo  = lo;
        cfg_frac_hi  = hi;
    endtask

    // driver: offer one byte, record what the frame must look like
    task automatic send(input logic [7:0] d, input int q, input int n, input int pt,
                        input logic [7:0] lo, input logic [1:0] hi, input int chg_after);
        exp_t e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        set_cfg(q, n, pt, lo, hi);
        in_data  = d;
        in_valid = 1'b1;
        e.data = d; e.q = q; e.n = n; e.pt = pt; e.mask = {hi, lo};
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        if (chg_after > 0) begin
            repeat (chg_after) @(negedge clk);
            // R6: scramble configuration mid-frame
            set_cfg(q + 2, n + 4, 0, ~lo, ~hi);
        end
    endtask

    task automatic wait_frames(input int k);
        while (frames_done < k) @(negedge clk);
    endtask

    function automatic void pick_mask(input int digit, output logic [7:0] lo,
                                      output logic [1:0] hi);
        case (digit)
            0:  begin lo = 8'h00; hi = 2'd0; end
            1:  begin lo = 8'h01; hi = 2'd0; end
            2:  begin lo = 8'h05; hi = 2'd0; end
            3:  begin lo = 8'h15; hi = 2'd0; end
            4:  begin lo = 8'h55; hi = 2'd0; end
            5:  begin lo = 8'h57; hi = 2'd0; end
            6:  begin lo = 8'h57; hi = 2'd1; end
            7:  begin lo = 8'h77; hi = 2'd1; end
            8:  begin lo = 8'h7F; hi = 2'd1; end
            9:  begin lo = 8'hFF; hi = 2'd1; end
            default: begin lo = 8'hFF; hi = 2'd3; end
        endcase
    endfunction

    // monitor / scoreboard
    initial begin : monitor
        int   gap, cyc, nstr, tot, s, len;
        bit   rdy_ok, pos_ok, val_ok;
        int   str_cyc[10];
        logic str_val[10];
        int   exp_cyc[10];
        logic exp_val[10];
        int   bad_act, bad_exp;
        exp_t e;
        @(negedge clk);
        forever begin
            gap = 0;
            while (!busy) begin gap++; @(negedge clk); end
            last_gap = gap;
            cyc = 0; nstr = 0; rdy_ok = 1'b1;
            while (busy) begin
                cyc++;
                if (in_ready) rdy_ok = 1'b0;
                if (samp_strobe) begin
                    if (nstr < 10) begin
                        str_cyc[nstr] = cyc;
                        str_val[nstr] = tx_line;
                    end
                    nstr++;
                end
                @(negedge clk);
            end
            last_len = cyc;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected frame", 1, 0);
            end else begin
                e = exp_q.pop_front();
                s = 1;
                for (int i = 0; i < 10; i++) begin
                    len = (e.n + 1 + int'(e.mask[i])) * e.q;
                    exp_cyc[i] = s + (e.pt + 1) * e.q - 1;
                    s += len;
                    if (i == 0)      exp_val[i] = 1'b0;
                    else if (i == 9) exp_val[i] = 1'b1;
                    else             exp_val[i] = e.data[i-1];
                end
                tot = s - 1;
                check(cyc == tot, "R3", "frame length in cycles", cyc, tot);
                check(rdy_ok, "R5", "in_ready low while busy", 0, 1);
                check(nstr == 10, "R4", "strobes per frame", nstr, 10);
                pos_ok = 1'b1; val_ok = 1'b1; bad_act = 0; bad_exp = 0;
                for (int i = 0; i < 10 && i < nstr; i++) begin
                    if (pos_ok && str_cyc[i] != exp_cyc[i]) begin
                        pos_ok = 1'b0; bad_act = str_cyc[i]; bad_exp = exp_cyc[i];
                    end
                end
                check(pos_ok, "R4", "strobe cycle", bad_act, bad_exp);
                bad_act = 0; bad_exp = 0;
                for (int i = 0; i < 10 && i < nstr; i++) begin
                    if (val_ok && str_val[i] != exp_val[i]) begin
                        val_ok = 1'b0; bad_act = i; bad_exp = int'(exp_val[i]);
                    end
                end
                check(val_ok, "R2", "line level at strobe (slot index / expected)",
                      bad_act, bad_exp);
            end
            frames_done++;
        end
    end

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            check(1'b0, "WDOG", "watchdog expired", WDOG, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int q, sc, frac, digit;
        logic [7:0] lo;
        logic [1:0] hi;
        longint fclk, baud;
        repeat (3) @(negedge clk);
        // R1 during reset
        check(tx_line && in_ready && !busy && !samp_strobe, "R1", "outputs in reset",
              int'({tx_line, in_ready, busy, samp_strobe}), 4'b1100);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line && in_ready && !busy && !samp_strobe, "R1", "outputs after reset",
              int'({tx_line, in_ready, busy, samp_strobe}), 4'b1100);

        // R2 R3 R4: plain frame, one cycle per tick, no stretch
        send(8'hA5, 1, 3, 1, 8'h00, 2'd0, 0);
        wait_frames(1);
        // R3: alternating stretch, quotient 3
        send(8'h3C, 3, 4, 1, 8'h55, 2'd0, 0);
        wait_frames(2);
        // R3: every slot stretched
        send(8'h00, 2, 7, 3, 8'hFF, 2'd3, 0);
        wait_frames(3);
        send(8'hFF, 2, 7, 7, 8'h00, 2'd0, 0);
        wait_frames(4);
        // R3: only start slot and stop slot stretched
        send(8'h81, 1, 5, 2, 8'h01, 2'd2, 0);
        wait_frames(5);
        check(tx_line && in_ready, "R2", "idle line high between frames",
              int'(tx_line), 1);

        // R6: configuration changed 20 cycles into the frame
        send(8'h5A, 2, 5, 2, 8'h0F, 2'd1, 20);
        wait_frames(6);

        // R8: back-to-back with valid held high
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        set_cfg(1, 3, 1, 8'h12, 2'd1);
        in_data = 8'h12; in_valid = 1'b1;
        exp_q.push_back('{data: 8'h12, q: 1, n: 3, pt: 1, mask: 10'h112});
        @(negedge clk);
        in_data = 8'h34;
        exp_q.push_back('{data: 8'h34, q: 1, n: 3, pt: 1, mask: 10'h112});
        while (!in_ready) @(negedge clk);
        check(tx_line, "R8", "line high in gap cycle", int'(tx_line), 1);
        @(negedge clk);
        in_valid = 1'b0;
        wait_frames(8);
        check(last_gap == 1, "R8", "idle cycles between frames", last_gap, 1);

        // R7: 40 MHz clock, 115200 baud, compensation chosen by first fraction digit
        fclk = 40000000; baud = 115200;
        q     = int'((fclk + 256 * baud - 1) / (256 * baud));
        sc    = int'(fclk / (q * baud));
        frac  = int'(((fclk * 100) / q / baud) % 100);
        digit = (frac + 5) / 10;
        pick_mask(digit, lo, hi);
        send(8'h55, q, sc - 1, (sc >> 1) - 1, lo, hi, 0);
        wait_frames(9);
        check(last_len == 3472, "R7", "compensated frame cycles", last_len, 3472);
        check(int'(fclk * 10 / last_len) == 115207, "R7", "average bit rate",
              int'(fclk * 10 / last_len), 115207);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R5", "frames outstanding", exp_q.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule